// File: doc/BRIEF.md
# Block Audio Playback DMA

This engine streams a circular playback buffer from memory toward an audio output path, one 32-byte block per sample tick. Software programs a 32-bit buffer start address as two 16-bit halves, then writes a control word that carries an enable flag and a block count. That write loads the engine's read pointer and its remaining-block counter. The data path, the output FIFO and any rate conversion sit outside the block.

Each tick that finds the engine enabled and with blocks left issues one memory read request at the current pointer. The pointer then moves on by one block. When the last block of the buffer is fetched, the engine raises a one-cycle interrupt request and rewinds by itself: the counter reloads from the programmed count and the pointer returns to the start address. Software can therefore reprogram the start address for the next buffer while the current one plays. A tick that cannot fetch produces a silence pulse instead of a request. A reset strobe from outside clears the control word.

Top module: `audio_blk_dma`

## Requirements
- R1: After rst_ni deasserts, all four registers read zero and mem_req_o, silence_o and irq_o are low.
- R2: Register index 0 holds start address bits 31:16 and index 1 holds bits 15:0; each is written and read back on its own.
- R3: Register index 2 is the control word: bit 15 is enable and bits 14:0 are the block count. It reads back as last written.
- R4: A control-word write loads the read pointer from the start address and the remaining counter from the written count. A tick in that same cycle yields a silence pulse and no request.
- R5: A tick with enable set and a nonzero remaining count gives a one-cycle mem_req_o pulse one cycle later. mem_addr_o then equals start + 32 x (blocks already fetched in this buffer).
- R6: The request that fetches the last block of a buffer comes with a one-cycle irq_o pulse. The counter then reloads from the count and the next request addresses the start address.
- R7: Register index 3 reads the remaining count minus one, or zero when the remaining count is zero.
- R8: A tick while disabled, or with a remaining count of zero, gives a one-cycle silence_o pulse one cycle later and no request.
- R9: A soft_rst_i pulse clears the control word, so enable and count read zero. A control write in the same cycle is discarded, and later ticks give silence.
- R10: Writes to register index 3 change neither the remaining count nor the fetch sequence.
- R11: A start-address write in the middle of a buffer leaves the current pointer unchanged. The new start address takes effect at the next rewind.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Strobe that clears the control word |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 2 | Register index (0 start hi, 1 start lo, 2 control, 3 remaining) |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational from reg_addr_i) |
| tick_i | input | 1 | Single-cycle pulse requesting one block |
| mem_req_o | output | 1 | Memory read request valid |
| mem_addr_o | output | 32 | Memory read request byte address |
| silence_o | output | 1 | Tick served with silence |
| irq_o | output | 1 | End-of-buffer interrupt request pulse |

## Verification
A wrong pointer shows on mem_addr_o at the very next tick. A wrong remaining count shows in two places: at once on the zero-based readback of register index 3, and as an irq_o pulse on the wrong tick, at most one buffer length later. The bench sweeps buffer lengths and start addresses, including one near the top of the address space so the pointer wraps. For every tick it predicts the address, interrupt and readback arithmetically, so any drift shows up within one buffer. The ordering corners are driven directly: a tick that collides with a control write, a strobe that collides with a control write, a start-address change in mid-buffer and a write to the read-only counter register.

// File: rtl/audio_blk_dma_pkg.sv
`timescale 1ns/1ps
package audio_blk_dma_pkg;
  localparam int REG_W = 16;
  localparam int RA_W  = 2;
  localparam int CNT_W = REG_W - 1;
  localparam int EN_BIT = REG_W - 1;

  typedef enum logic [RA_W-1:0] {
    REG_START_HI = 2'd0,
    REG_START_LO = 2'd1,
    REG_CTRL     = 2'd2,
    REG_REMAIN   = 2'd3
  } reg_idx_e;
endpackage

// File: rtl/adma_regs.sv
`timescale 1ns/1ps
module adma_regs
  import audio_blk_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              we_i,
  input  logic [RA_W-1:0]   addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  rem_cnt_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic              en_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_cnt_o
);
  localparam int NUM_HALF = ADDR_W / REG_W;

  // start address halves; half 0 is the low half
  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    localparam logic [RA_W-1:0] IDX = RA_W'(REG_START_LO) - RA_W'(h);
    logic [REG_W-1:0] half_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      half_q <= '0;
      else if (we_i && addr_i == IDX)   half_q <= wdata_i;
    end
    assign start_addr_o[h*REG_W +: REG_W] = half_q;
  end

  logic ctrl_sel;
  assign ctrl_sel = we_i && (addr_i == REG_CTRL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o  <= 1'b0;
      cnt_o <= '0;
    end else if (soft_rst_i) begin
      en_o  <= 1'b0;
      cnt_o <= '0;
    end else if (ctrl_sel) begin
      en_o  <= wdata_i[EN_BIT];
      cnt_o <= wdata_i[CNT_W-1:0];
    end
  end

  // strobe wins over a colliding control write
  assign load_o     = ctrl_sel && !soft_rst_i;
  assign load_cnt_o = wdata_i[CNT_W-1:0];

  always_comb begin
    unique case (reg_idx_e'(addr_i))
      REG_START_HI: rdata_o = start_addr_o[ADDR_W-1 -: REG_W];
      REG_START_LO: rdata_o = start_addr_o[REG_W-1:0];
      REG_CTRL:     rdata_o = {en_o, cnt_o};
      REG_REMAIN:   rdata_o = (rem_cnt_i != '0) ? {1'b0, rem_cnt_i - CNT_W'(1)} : '0;
      default:      rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/adma_engine.sv
`timescale 1ns/1ps
module adma_engine
  import audio_blk_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_cnt_i,
  output logic [CNT_W-1:0]  rem_cnt_o,
  output logic [ADDR_W-1:0] rd_ptr_o,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              silence_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BLK_BYTES);

  logic fetch, last;
  assign fetch = tick_i && !load_i && en_i && (rem_cnt_o != '0);
  assign last  = (rem_cnt_o == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_cnt_o <= '0;
      rd_ptr_o  <= '0;
      req_o     <= 1'b0;
      addr_o    <= '0;
      silence_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      req_o     <= fetch;
      silence_o <= tick_i && !fetch;
      irq_o     <= fetch && last;
      if (fetch) addr_o <= rd_ptr_o;
      if (load_i) begin
        rd_ptr_o  <= start_addr_i;
        rem_cnt_o <= load_cnt_i;
      end else if (fetch) begin
        if (last) begin
          rd_ptr_o  <= start_addr_i;
          rem_cnt_o <= cnt_i;
        end else begin
          rd_ptr_o  <= rd_ptr_o + STEP;
          rem_cnt_o <= rem_cnt_o - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/audio_blk_dma.sv
`timescale 1ns/1ps
module audio_blk_dma
  import audio_blk_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              reg_we_i,
  input  logic [RA_W-1:0]   reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              tick_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              silence_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] start_addr, rd_ptr;
  logic              ctrl_en, load;
  logic [CNT_W-1:0]  ctrl_cnt, load_cnt, rem_cnt;

  adma_regs #(.ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .soft_rst_i,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rem_cnt_i(rem_cnt), .rdata_o(reg_rdata_o),
    .start_addr_o(start_addr), .en_o(ctrl_en), .cnt_o(ctrl_cnt),
    .load_o(load), .load_cnt_o(load_cnt)
  );

  adma_engine #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) i_engine (
    .clk_i, .rst_ni, .tick_i,
    .en_i(ctrl_en), .cnt_i(ctrl_cnt), .start_addr_i(start_addr),
    .load_i(load), .load_cnt_i(load_cnt),
    .rem_cnt_o(rem_cnt), .rd_ptr_o(rd_ptr),
    .req_o(mem_req_o), .addr_o(mem_addr_o),
    .silence_o, .irq_o
  );
endmodule

// File: rtl/audio_blk_dma_chk.sv
`timescale 1ns/1ps
module audio_blk_dma_chk
  import audio_blk_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              soft_rst_i,
  input logic              reg_we_i,
  input logic [RA_W-1:0]   reg_addr_i,
  input logic [CNT_W-1:0]  wr_cnt_i,
  input logic              tick_i,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              silence_o,
  input logic              irq_o,
  input logic              ctrl_en,
  input logic [CNT_W-1:0]  ctrl_cnt,
  input logic [CNT_W-1:0]  rem_cnt,
  input logic [ADDR_W-1:0] rd_ptr,
  input logic [ADDR_W-1:0] start_addr
);
  logic ctrl_wr;
  assign ctrl_wr = reg_we_i && (reg_addr_i == REG_CTRL);

  // R4
  load_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && !soft_rst_i) |=> (rd_ptr == $past(start_addr) && rem_cnt == $past(wr_cnt_i)));

  // R5
  fetch_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ctrl_wr && ctrl_en && rem_cnt != '0) |=> (mem_req_o && !silence_o && mem_addr_o == $past(rd_ptr)));

  // R6
  irq_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mem_req_o && rd_ptr == $past(start_addr) && rem_cnt == $past(ctrl_cnt)));

  // R8
  silence_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (!ctrl_en || rem_cnt == '0)) |=> (silence_o && !mem_req_o && !irq_o));

  // R9
  soft_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!ctrl_en && ctrl_cnt == '0));

  // R10
  remain_ro_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_REMAIN && !tick_i) |=> ($stable(rem_cnt) && $stable(rd_ptr)));
endmodule

bind audio_blk_dma audio_blk_dma_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .wr_cnt_i(reg_wdata_i[audio_blk_dma_pkg::CNT_W-1:0]),
  .tick_i(tick_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .silence_o(silence_o), .irq_o(irq_o),
  .ctrl_en(ctrl_en), .ctrl_cnt(ctrl_cnt), .rem_cnt(rem_cnt),
  .rd_ptr(rd_ptr), .start_addr(start_addr)
);

// File: tb/test_audio_blk_dma.sv
`timescale 1ns/1ps
module test_audio_blk_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        tick = 1'b0;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        silence;
  logic        irq;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  audio_blk_dma i_audio_blk_dma (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .tick_i(tick),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .silence_o(silence), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic tick_once();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_start(input logic [31:0] s);
    wr(2'd0, s[31:16]);
    wr(2'd1, s[15:0]);
  endtask

  initial begin
    logic [15:0] d;
    logic [31:0] starts [3];
    starts[0] = 32'h0000_1000;
    starts[1] = 32'h8123_4560;
    starts[2] = 32'hFFFF_FFC0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 4; i++) begin
      rd(2'(i), d);
      chk("R1 reg", {16'd0, d}, 32'd0);
    end
    chk("R1 outs", {29'd0, mem_req, silence, irq}, 32'd0);

    // R2 address halves
    wr(2'd0, 16'hA5C3);
    rd(2'd0, d); chk("R2 hi", {16'd0, d}, 32'h0000_A5C3);
    rd(2'd1, d); chk("R2 lo untouched", {16'd0, d}, 32'd0);
    wr(2'd1, 16'h3C5A);
    rd(2'd1, d); chk("R2 lo", {16'd0, d}, 32'h0000_3C5A);
    rd(2'd0, d); chk("R2 hi kept", {16'd0, d}, 32'h0000_A5C3);

    // R3 control readback
    wr(2'd2, 16'h0007);
    rd(2'd2, d); chk("R3 ctrl dis", {16'd0, d}, 32'h0000_0007);
    rd(2'd3, d); chk("R7 rem", {16'd0, d}, 32'd6);
    tick_once();
    chk("R8 disabled silence", {30'd0, silence, mem_req}, 32'd2);

    // R5 R6 R7 sweep over length and start
    for (int si = 0; si < 3; si++) begin
      for (int n = 1; n <= 6; n++) begin
        set_start(starts[si]);
        wr(2'd2, 16'h8000 | 16'(n));
        rd(2'd2, d); chk("R3 ctrl en", {16'd0, d}, 32'h8000 | n);
        rd(2'd3, d); chk("R4 load rem", {16'd0, d}, 32'(n - 1));
        for (int k = 0; k < 2 * n + 1; k++) begin
          int blk;
          logic exp_irq;
          blk = k % n;
          exp_irq = (blk == n - 1);
          tick_once();
          chk("R5 req", {30'd0, mem_req, silence}, 32'd2);
          chk("R5 addr", mem_addr, starts[si] + 32'(32 * blk));
          chk("R6 irq", {31'd0, irq}, {31'd0, exp_irq});
          rd(2'd3, d);
          chk("R7 rem", {16'd0, d}, exp_irq ? 32'(n - 1) : 32'(n - 2 - blk));
        end
      end
    end

    // R8 zero count enabled, R7 zero readback
    wr(2'd2, 16'h8000);
    rd(2'd3, d); chk("R7 zero", {16'd0, d}, 32'd0);
    tick_once();
    chk("R8 zero count", {29'd0, mem_req, silence, irq}, 32'd2);

    // R4 tick colliding with control write
    set_start(32'h0000_2000);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h8003; tick = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; tick = 1'b0;
    chk("R4 collide silence", {29'd0, mem_req, silence, irq}, 32'd2);
    rd(2'd3, d); chk("R4 collide rem", {16'd0, d}, 32'd2);
    tick_once();
    chk("R4 first addr", mem_addr, 32'h0000_2000);

    // R10 write to remaining ignored
    wr(2'd3, 16'h1234);
    rd(2'd3, d); chk("R10 rem kept", {16'd0, d}, 32'd1);
    rd(2'd2, d); chk("R10 ctrl kept", {16'd0, d}, 32'h8003);
    tick_once();
    chk("R10 seq addr", mem_addr, 32'h0000_2020);

    // R11 start change mid-buffer
    set_start(32'h0000_5000);
    tick_once();
    chk("R11 old ptr", mem_addr, 32'h0000_2040);
    chk("R11 irq", {31'd0, irq}, 32'd1);
    tick_once();
    chk("R11 new start", mem_addr, 32'h0000_5000);

    // R9 soft reset
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    rd(2'd2, d); chk("R9 ctrl clr", {16'd0, d}, 32'd0);
    tick_once();
    chk("R9 silence", {29'd0, mem_req, silence, irq}, 32'd2);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h8004; soft_rst = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; soft_rst = 1'b0;
    rd(2'd2, d); chk("R9 strobe wins", {16'd0, d}, 32'd0);
    tick_once();
    chk("R9 still silent", {30'd0, mem_req, silence}, 32'd1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule